// File: doc/BRIEF.md
# Horizontal Line Timing Generator

This block generates the horizontal timing of one display line for a flat panel or a VGA monitor. It advances once for each pixel-clock enable. One packed 32-bit timing word supplies the line length and the three blanking intervals. Each line passes through four phases in a fixed order: the visible pixels, the front porch, the line pulse, and the back porch. The line pulse serves as the line clock of a passive panel or as the horizontal sync of an active display. One timing word format serves both the panel channel and the monitor channel.

The block drives four outputs. A data-enable strobe marks the visible pixels. A pixel index counts across the visible part of the line. The line pulse output is the third. The fourth is a single-cycle end-of-line strobe that a vertical counter can use. The timing word is copied into shadow registers only at the close of a back porch, so software may rewrite it at any time without breaking the line in progress. The pixel-clock divider, vertical timing and pixel fetch are separate blocks.

Top module: `hline_timer`

## Requirements
- R1: The timing word fields are packed as follows. Bits 7:2 hold the line length, written as (visible pixels / 16) - 1. Bits 13:8 hold the pulse width minus one. Bits 23:16 hold the front porch minus one. Bits 31:24 hold the back porch minus one. Bits 1:0 and 15:14 have no effect on any output.
- R2: While `rst` is high on a clock edge, the block resets to the last cycle of a one-clock back porch. In that state `pix_de`=0, `pix_idx`=0, `line_end`=0 and the line pulse is deasserted. The first line starts on the next enabled pixel clock.
- R3: At the start of each line, `pix_de` is high for exactly (L+1)*16 enabled pixel clocks, where L is the line-length field.
- R4: While `pix_de` is high, `pix_idx` runs 0, 1, 2, ... and rises by one per enabled pixel clock. While `pix_de` is low, `pix_idx` is 0.
- R5: After the visible pixels come three intervals in order. The front porch lasts F+1 pixel clocks, the line pulse lasts W+1 and the back porch lasts B+1. The line pulse is never asserted while `pix_de` is high.
- R6: `line_end` is high for exactly one clock, in the first cycle in which the line pulse is asserted.
- R7: When `passive_mode`=0 and `sync_invert`=1, `line_sync` is active-low. In every other case it is active-high, and in passive mode `sync_invert` has no effect.
- R8: The timing word is sampled only on the enabled pixel clock that ends a back porch. A change made at any other time takes effect at the start of the next line.
- R9: While `pix_en` is low, `pix_de`, `pix_idx` and the line pulse hold their values, and no `line_end` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-clock enable; timing advances only when high |
| timing_word | input | 32 | Packed horizontal timing fields |
| passive_mode | input | 1 | 1: pulse is a passive-panel line clock; 0: horizontal sync |
| sync_invert | input | 1 | Inverts the sync polarity in active mode |
| pix_de | output | 1 | Visible-pixel strobe |
| line_sync | output | 1 | Line clock or horizontal sync pulse |
| pix_idx | output | 10 | Pixel index within the visible region |
| line_end | output | 1 | One-clock end-of-line strobe at the start of the pulse |

## Verification
The bench builds the block with its default field widths: a 6-bit line-length field in units of 16 pixels, a 6-bit pulse field and 8-bit porch fields. With these widths, a sweep over small line lengths, pulse widths and porches covers every phase boundary within a few dozen clocks per line. A single maximal line (1024 pixels, 64-clock pulse, 256-clock porches) then covers the upper end of every counter. Further runs cover gated pixel enables, rewrites of the timing word in the middle of a line, and every combination of mode and polarity against an arithmetic model of the line position.

// File: rtl/hline_pkg.sv
package hline_pkg;

  typedef enum logic [1:0] {
    PH_ACTIVE = 2'd0,
    PH_FPORCH = 2'd1,
    PH_SYNC   = 2'd2,
    PH_BPORCH = 2'd3
  } hphase_t;

  function automatic hphase_t phase_after(input hphase_t ph);
    case (ph)
      PH_ACTIVE: phase_after = PH_FPORCH;
      PH_FPORCH: phase_after = PH_SYNC;
      PH_SYNC:   phase_after = PH_BPORCH;
      default:   phase_after = PH_ACTIVE;
    endcase
  endfunction

endpackage

// File: rtl/hline_shadow.sv
module hline_shadow #(
  parameter int WORD_W   = 32,
  parameter int PPL_W    = 6,
  parameter int SYNC_W   = 6,
  parameter int PORCH_W  = 8,
  parameter int PPL_LSB  = 2,
  parameter int SYNC_LSB = 8,
  parameter int FP_LSB   = 16,
  parameter int BP_LSB   = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [WORD_W-1:0]  word,
  output logic [PPL_W-1:0]   ppl_q,
  output logic [SYNC_W-1:0]  hsw_q,
  output logic [PORCH_W-1:0] fp_q,
  output logic [PORCH_W-1:0] bp_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ppl_q <= '0;
      hsw_q <= '0;
      fp_q  <= '0;
      bp_q  <= '0;
    end else if (load) begin
      ppl_q <= word[PPL_LSB  +: PPL_W];
      hsw_q <= word[SYNC_LSB +: SYNC_W];
      fp_q  <= word[FP_LSB   +: PORCH_W];
      bp_q  <= word[BP_LSB   +: PORCH_W];
    end
  end

endmodule

// File: rtl/hline_seq.sv
module hline_seq
  import hline_pkg::*;
#(
  parameter int PPL_W     = 6,
  parameter int SYNC_W    = 6,
  parameter int PORCH_W   = 8,
  parameter int UNIT_LOG2 = 4,
  parameter int CNT_W     = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_en,
  input  logic [PPL_W-1:0]   ppl,
  input  logic [SYNC_W-1:0]  hsw,
  input  logic [PORCH_W-1:0] fp,
  input  logic [PORCH_W-1:0] bp,
  output hphase_t            nxt_phase,
  output logic [CNT_W-1:0]   nxt_cnt,
  output logic               load_o,
  output logic               enter_sync_o
);

  hphase_t          phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             at_lim;

  always_comb begin
    case (phase_q)
      PH_ACTIVE: lim = CNT_W'({ppl, {UNIT_LOG2{1'b1}}});
      PH_FPORCH: lim = CNT_W'(fp);
      PH_SYNC:   lim = CNT_W'(hsw);
      default:   lim = CNT_W'(bp);
    endcase
  end

  assign at_lim = (cnt_q == lim);

  always_comb begin
    nxt_phase = phase_q;
    nxt_cnt   = cnt_q;
    if (pix_en) begin
      if (at_lim) begin
        nxt_phase = phase_after(phase_q);
        nxt_cnt   = '0;
      end else begin
        nxt_cnt = cnt_q + 1'b1;
      end
    end
  end

  assign load_o       = pix_en && at_lim && (phase_q == PH_BPORCH);
  assign enter_sync_o = pix_en && at_lim && (phase_q == PH_FPORCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_BPORCH;
      cnt_q   <= '0;
    end else begin
      phase_q <= nxt_phase;
      cnt_q   <= nxt_cnt;
    end
  end

endmodule

// File: rtl/hline_out.sv
module hline_out
  import hline_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  hphase_t          nxt_phase,
  input  logic [CNT_W-1:0] nxt_cnt,
  input  logic             enter_sync,
  output logic             de_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             in_sync_q,
  output logic             end_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      de_q      <= 1'b0;
      idx_q     <= '0;
      in_sync_q <= 1'b0;
      end_q     <= 1'b0;
    end else begin
      de_q      <= (nxt_phase == PH_ACTIVE);
      idx_q     <= (nxt_phase == PH_ACTIVE) ? nxt_cnt[IDX_W-1:0] : '0;
      in_sync_q <= (nxt_phase == PH_SYNC);
      end_q     <= enter_sync;
    end
  end

endmodule

// File: rtl/hline_timer.sv
module hline_timer
  import hline_pkg::*;
#(
  parameter int PPL_W     = 6,
  parameter int SYNC_W    = 6,
  parameter int PORCH_W   = 8,
  parameter int UNIT_LOG2 = 4,
  localparam int WORD_W   = 32,
  localparam int IDX_W    = PPL_W + UNIT_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic [WORD_W-1:0] timing_word,
  input  logic              passive_mode,
  input  logic              sync_invert,
  output logic              pix_de,
  output logic              line_sync,
  output logic [IDX_W-1:0]  pix_idx,
  output logic              line_end
);

  localparam int PPL_LSB  = 2;
  localparam int SYNC_LSB = 8;
  localparam int FP_LSB   = 16;
  localparam int BP_LSB   = 24;
  localparam int CW_A     = (IDX_W > PORCH_W) ? IDX_W : PORCH_W;
  localparam int CNT_W    = (CW_A > SYNC_W) ? CW_A : SYNC_W;

  logic [PPL_W-1:0]   ppl_s;
  logic [SYNC_W-1:0]  hsw_s;
  logic [PORCH_W-1:0] fp_s;
  logic [PORCH_W-1:0] bp_s;
  hphase_t            nxt_phase;
  logic [CNT_W-1:0]   nxt_cnt;
  logic               load;
  logic               enter_sync;
  logic               in_sync;

  hline_shadow #(
    .WORD_W(WORD_W), .PPL_W(PPL_W), .SYNC_W(SYNC_W), .PORCH_W(PORCH_W),
    .PPL_LSB(PPL_LSB), .SYNC_LSB(SYNC_LSB), .FP_LSB(FP_LSB), .BP_LSB(BP_LSB)
  ) u_shadow (
    .clk(clk), .rst(rst), .load(load), .word(timing_word),
    .ppl_q(ppl_s), .hsw_q(hsw_s), .fp_q(fp_s), .bp_q(bp_s)
  );

  hline_seq #(
    .PPL_W(PPL_W), .SYNC_W(SYNC_W), .PORCH_W(PORCH_W),
    .UNIT_LOG2(UNIT_LOG2), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .pix_en(pix_en),
    .ppl(ppl_s), .hsw(hsw_s), .fp(fp_s), .bp(bp_s),
    .nxt_phase(nxt_phase), .nxt_cnt(nxt_cnt),
    .load_o(load), .enter_sync_o(enter_sync)
  );

  hline_out #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_out (
    .clk(clk), .rst(rst), .nxt_phase(nxt_phase), .nxt_cnt(nxt_cnt),
    .enter_sync(enter_sync), .de_q(pix_de), .idx_q(pix_idx),
    .in_sync_q(in_sync), .end_q(line_end)
  );

  assign line_sync = in_sync ^ (sync_invert & ~passive_mode);

endmodule

// File: rtl/hline_timer_chk.sv
module hline_timer_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_en,
  input logic             passive_mode,
  input logic             sync_invert,
  input logic             pix_de,
  input logic             line_sync,
  input logic [IDX_W-1:0] pix_idx,
  input logic             line_end
);

  logic pulse_on;
  assign pulse_on = line_sync ^ (sync_invert & ~passive_mode);

  AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
    line_end |=> !line_end); // R6

  AST_END_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
    line_end |-> pulse_on); // R6

  AST_NO_PULSE_IN_DE: assert property (@(posedge clk) disable iff (rst)
    pix_de |-> !pulse_on); // R5

  AST_IDX_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !pix_de |-> (pix_idx == '0)); // R4

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (pix_en && pix_de) |=> (!pix_de || pix_idx == IDX_W'($past(pix_idx) + 1'b1))); // R4

  AST_HOLD_GATED: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(pix_de) && $stable(pix_idx) && !line_end)); // R9

endmodule

bind hline_timer hline_timer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .passive_mode(passive_mode),
  .sync_invert(sync_invert), .pix_de(pix_de), .line_sync(line_sync),
  .pix_idx(pix_idx), .line_end(line_end)
);

// File: tb/tb_hline_timer.sv
module tb_hline_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_en = 1'b0;
  logic [31:0] timing_word = '0;
  logic        passive_mode = 1'b0;
  logic        sync_invert = 1'b0;
  logic        pix_de;
  logic        line_sync;
  logic [9:0]  pix_idx;
  logic        line_end;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // model of the line position
  int m_ppl, m_hsw, m_fp, m_bp, pos;

  always #4 clk = ~clk;

  hline_timer dut (
    .clk(clk), .rst(rst), .pix_en(pix_en), .timing_word(timing_word),
    .passive_mode(passive_mode), .sync_invert(sync_invert),
    .pix_de(pix_de), .line_sync(line_sync), .pix_idx(pix_idx),
    .line_end(line_end)
  );

  function automatic logic [31:0] mk(int ppl, int hsw, int fp, int bp, int junk);
    logic [31:0] w;
    w = '0;
    w[7:2]   = ppl[5:0];
    w[13:8]  = hsw[5:0];
    w[15:14] = junk[3:2];
    w[23:16] = fp[7:0];
    w[31:24] = bp[7:0];
    w[1:0]   = junk[1:0];
    return w;
  endfunction

  function automatic int n_act();  return (m_ppl + 1) * 16; endfunction
  function automatic int period(); return n_act() + m_fp + m_hsw + m_bp + 3; endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (pos=%0d)", req, what, act, exp, pos);
    end
  endtask

  task automatic check_outputs(string ctx, bit end_exp);
    int n, s0, s1, de, idx, ins, pol;
    n   = n_act();
    s0  = n + m_fp + 1;
    s1  = s0 + m_hsw + 1;
    de  = (pos < n) ? 1 : 0;
    idx = de ? pos : 0;
    ins = (pos >= s0 && pos < s1) ? 1 : 0;
    pol = (sync_invert && !passive_mode) ? 1 : 0;
    check({ctx, " R3"}, "pix_de", int'(pix_de), de);
    check({ctx, " R4"}, "pix_idx", int'(pix_idx), idx);
    check({ctx, " R5 R7"}, "line_sync", int'(line_sync), ins ^ pol);
    check({ctx, " R6"}, "line_end", int'(line_end), int'(end_exp));
  endtask

  // called at a negedge: drive, advance one clock, check at next negedge
  task automatic step(string ctx, bit en);
    bit e_end;
    pix_en = en;
    @(posedge clk);
    e_end = 1'b0;
    if (en) begin
      if (pos == period() - 1) begin
        pos   = 0;
        m_ppl = int'(timing_word[7:2]);
        m_hsw = int'(timing_word[13:8]);
        m_fp  = int'(timing_word[23:16]);
        m_bp  = int'(timing_word[31:24]);
      end else begin
        pos++;
      end
      e_end = (pos == n_act() + m_fp + 1);
    end
    @(negedge clk);
    check_outputs(ctx, e_end);
  endtask

  task automatic do_reset(logic [31:0] w);
    @(negedge clk);
    rst = 1'b1;
    timing_word = w;
    pix_en = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_ppl = 0; m_hsw = 0; m_fp = 0; m_bp = 0;
    pos = period() - 1;
    // R2: outputs at rest after reset
    check("R2", "reset pix_de", int'(pix_de), 0);
    check("R2", "reset pix_idx", int'(pix_idx), 0);
    check("R2", "reset line_end", int'(line_end), 0);
    check("R2", "reset line_sync", int'(line_sync),
          (sync_invert && !passive_mode) ? 1 : 0);
  endtask

  initial begin
    int cfg;
    cfg = 0;
    // R1 R3 R4 R5 R6 R7: sweep of small configurations, reserved bits varied
    for (int p = 0; p < 2; p++)
      for (int h = 0; h < 3; h += 2)
        for (int f = 0; f < 4; f += 3)
          for (int b = 0; b < 2; b++) begin
            passive_mode = cfg[0];
            sync_invert  = cfg[1];
            do_reset(mk(p, h, f, b, cfg % 16));
            for (int i = 0; i < 2 * ((p + 1) * 16 + h + f + b + 3) + 2; i++)
              step("R1", 1'b1);
            cfg++;
          end

    // R8: rewrite mid-line, takes effect on the next line only
    passive_mode = 1'b0; sync_invert = 1'b0;
    do_reset(mk(0, 1, 2, 1, 0));
    for (int i = 0; i < 8; i++) step("R8", 1'b1);
    timing_word = mk(1, 3, 0, 4, 5);
    for (int i = 0; i < 30; i++) step("R8", 1'b1);
    timing_word = mk(0, 0, 5, 0, 10);
    for (int i = 0; i < 120; i++) step("R8", 1'b1);

    // R9: gated pixel enable, plus R7 polarity changes mid-run
    do_reset(mk(0, 2, 1, 2, 3));
    for (int i = 0; i < 150; i++) begin
      if (i % 7 == 0) begin
        passive_mode = i[3];
        sync_invert  = i[4];
      end
      step("R9 R7", (i % 3) != 1);
    end

    // R3 R4 R5: largest encodable line and blanking
    passive_mode = 1'b1; sync_invert = 1'b1;
    do_reset(mk(63, 63, 255, 255, 15));
    for (int i = 0; i < 1024 + 256 + 64 + 256 + 40; i++) step("R1 max", 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule